// File: doc/BRIEF.md
# Configuration Image Header Parser

The parser takes a configuration image one byte at a time over a valid/ready stream. Every image opens with a fixed 13-byte signature. Four informational text sections follow it, in this order: design name, device part, date and time. The parser passes the bytes of each text section to a side output, tagged with the section's index. It stores none of the text.

After the text sections comes a payload section. It carries a tag byte and then a 32-bit payload length, most significant byte first. The parser reports that length and then forwards exactly that many payload bytes on a second stream, marking the first and the last byte. Any input after the last payload byte is dropped.

Any fault in the header is permanent until the next reset. The parser raises an error flag, drops all further input and never offers a payload byte.

Top module: `cfg_hdr_parser`

## Requirements
- R1: The first 13 input bytes must equal 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01, in that order. A mismatch at any position raises `headerError` once that byte has been accepted.
- R2: After the signature come four text sections, each built as follows:
  - one tag byte, whose value is not checked;
  - a 2-byte length, high byte first;
  - that many content bytes.
  Only the content bytes appear on the field output: `fieldValid` is high, `fieldData` equals the input byte, and `fieldIdx` is 0, 1, 2 or 3 for design name, part, date and time.
- R3: A section length of zero is legal. The next byte is taken as the next tag, and no field byte is produced for that section.
- R4: The tag after the fourth text section must be 0x65. Any other value raises `headerError`.
- R5: The four bytes after the 0x65 tag form `payloadLength`, most significant byte first. `headerOk` rises once the fourth of these bytes has been accepted and stays high until reset.
- R6: Payload bytes appear on `payData` with `payValid`.
  - `payFirst` marks byte 1.
  - `payLast` marks byte number `payloadLength`.
- R7: Once the last payload byte has been accepted, further input is accepted with `inReady` high and dropped, and `payValid` stays low.
- R8: After an error, `headerError` stays high until reset, all input is accepted and dropped, and `payValid`, `fieldValid` and `headerOk` stay low.
- R9: While payload bytes are being forwarded, `inReady` equals `payReady`. During header parsing `inReady` is 1.
- R10: After reset, `headerOk`, `headerError`, `payValid` and `fieldValid` are 0 and `inReady` is 1.
- R11: A payload length of zero raises `headerOk` and forwards no payload byte. Later input is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Image byte |
| inValid | input | 1 | Image byte present |
| inReady | output | 1 | Parser accepts the byte |
| fieldData | output | 8 | Text section content byte |
| fieldIdx | output | 2 | Text section index (0 name, 1 part, 2 date, 3 time) |
| fieldValid | output | 1 | Content byte present on the field output |
| headerOk | output | 1 | Header parsed, payload length known |
| headerError | output | 1 | Header fault seen (sticky) |
| payloadLength | output | 32 | Payload length from the header |
| payData | output | 8 | Payload byte |
| payValid | output | 1 | Payload byte present |
| payFirst | output | 1 | First payload byte |
| payLast | output | 1 | Last payload byte |
| payReady | input | 1 | Payload consumer accepts the byte |

## Verification
Two events can fall on one byte:
- With a payload length of 1, the first-byte and last-byte markers both apply to the same byte.
- A consumer stall can land on that final byte, so the end of the payload has to wait while the input is held back.

The bench provokes this with a one-byte payload under a consumer that is mostly not ready. It compares `payFirst`, `payLast` and `inReady` against an expected per-byte classification on every clock. It also checks that the trailing bytes are dropped only after the stalled last byte has really been taken.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int SIG_LEN   = 13;
  localparam int SEC_LEN_W = 16;
  localparam logic [7:0] PAY_TAG = 8'h65;

  typedef enum logic [3:0] {
    ST_SIG, ST_TAG, ST_LHI, ST_LLO, ST_BODY, ST_ETAG, ST_PLEN, ST_PAY, ST_DONE, ST_ERR
  } parseState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic lenHiLd;
    logic lenLoLd;
    logic lenDec;
    logic fieldInc;
    logic plenShift;
    logic payInc;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic sigMatch;
    logic cntAtSigEnd;
    logic cntAtPlenEnd;
    logic lenLoZero;
    logic bodyEnd;
    logic fieldIsLast;
    logic tagMatch;
    logic plenZero;
    logic payIsFirst;
    logic payIsLast;
  } dpFlags_t;

  function automatic logic [7:0] sigByte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd1:                      b = 8'h09;
      4'd2, 4'd4, 4'd6, 4'd8:    b = 8'h0F;
      4'd3, 4'd5, 4'd7, 4'd9:    b = 8'hF0;
      4'd12:                     b = 8'h01;
      default:                   b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cfg_hdr_dp.sv
module cfg_hdr_dp
  import cfg_hdr_pkg::*;
#(
  parameter int FIELDS = 4,
  parameter int PLEN_W = 32,
  localparam int FIDX_W = $clog2(FIELDS),
  localparam int PLEN_BYTES = PLEN_W / 8,
  localparam int CNT_W = $clog2(SIG_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inData,
  input  dpCtl_t            ctl,
  output dpFlags_t          flags,
  output logic [FIDX_W-1:0] fieldIdx,
  output logic [PLEN_W-1:0] payloadLength
);

  logic [CNT_W-1:0]     byteCnt;
  logic [SEC_LEN_W-1:0] secLen;
  logic [PLEN_W-1:0]    payLen;
  logic [PLEN_W-1:0]    payCnt;
  logic [PLEN_W-1:0]    payLenNext;

  assign payLenNext = {payLen[PLEN_W-9:0], inData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt  <= '0;
      secLen   <= '0;
      payLen   <= '0;
      payCnt   <= '0;
      fieldIdx <= '0;
    end else begin
      if (ctl.cntClr)         byteCnt <= '0;
      else if (ctl.cntInc)    byteCnt <= byteCnt + 1'b1;
      if (ctl.lenHiLd)        secLen  <= SEC_LEN_W'(inData);
      else if (ctl.lenLoLd)   secLen  <= {secLen[SEC_LEN_W-9:0], inData};
      else if (ctl.lenDec)    secLen  <= secLen - 1'b1;
      if (ctl.fieldInc)       fieldIdx <= fieldIdx + 1'b1;
      if (ctl.plenShift)      payLen  <= payLenNext;
      if (ctl.payInc)         payCnt  <= payCnt + 1'b1;
    end
  end

  always_comb begin
    flags.sigMatch     = (inData == sigByte(4'(byteCnt)));
    flags.cntAtSigEnd  = (byteCnt == CNT_W'(SIG_LEN - 1));
    flags.cntAtPlenEnd = (byteCnt == CNT_W'(PLEN_BYTES - 1));
    flags.lenLoZero    = (secLen[7:0] == 8'h00) && (inData == 8'h00);
    flags.bodyEnd      = (secLen == SEC_LEN_W'(1));
    flags.fieldIsLast  = (fieldIdx == FIDX_W'(FIELDS - 1));
    flags.tagMatch     = (inData == PAY_TAG);
    flags.plenZero     = (payLenNext == '0);
    flags.payIsFirst   = (payCnt == '0);
    flags.payIsLast    = (payCnt + 1'b1 == payLen);
  end

  assign payloadLength = payLen;

  // R6
  pay_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.payInc |-> (payCnt < payLen));

endmodule

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     payReady,
  input  dpFlags_t flags,
  output dpCtl_t   ctl,
  output logic     inReady,
  output logic     payValid,
  output logic     payFirst,
  output logic     payLast,
  output logic     fieldValid,
  output logic     headerOk,
  output logic     headerError
);

  parseState_t state, stateNext;
  logic take;

  assign inReady     = (state == ST_PAY) ? payReady : 1'b1;
  assign take        = inValid && inReady;
  assign payValid    = (state == ST_PAY) && inValid;
  assign payFirst    = payValid && flags.payIsFirst;
  assign payLast     = payValid && flags.payIsLast;
  assign fieldValid  = (state == ST_BODY) && inValid;
  assign headerOk    = (state == ST_PAY) || (state == ST_DONE);
  assign headerError = (state == ST_ERR);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SIG;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    if (take) begin
      case (state)
        ST_SIG: begin
          if (!flags.sigMatch) stateNext = ST_ERR;
          else if (flags.cntAtSigEnd) begin
            ctl.cntClr = 1'b1;
            stateNext  = ST_TAG;
          end else ctl.cntInc = 1'b1;
        end
        ST_TAG: stateNext = ST_LHI;
        ST_LHI: begin
          ctl.lenHiLd = 1'b1;
          stateNext   = ST_LLO;
        end
        ST_LLO: begin
          ctl.lenLoLd = 1'b1;
          if (!flags.lenLoZero) stateNext = ST_BODY;
          else if (flags.fieldIsLast) stateNext = ST_ETAG;
          else begin
            ctl.fieldInc = 1'b1;
            stateNext    = ST_TAG;
          end
        end
        ST_BODY: begin
          ctl.lenDec = 1'b1;
          if (flags.bodyEnd) begin
            if (flags.fieldIsLast) stateNext = ST_ETAG;
            else begin
              ctl.fieldInc = 1'b1;
              stateNext    = ST_TAG;
            end
          end
        end
        ST_ETAG: begin
          if (!flags.tagMatch) stateNext = ST_ERR;
          else begin
            ctl.cntClr = 1'b1;
            stateNext  = ST_PLEN;
          end
        end
        ST_PLEN: begin
          ctl.plenShift = 1'b1;
          if (flags.cntAtPlenEnd) stateNext = flags.plenZero ? ST_DONE : ST_PAY;
          else ctl.cntInc = 1'b1;
        end
        ST_PAY: begin
          ctl.payInc = 1'b1;
          if (flags.payIsLast) stateNext = ST_DONE;
        end
        default: stateNext = state;
      endcase
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    headerError |=> headerError);

  // R1
  err_on_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(headerError) |-> $past(inValid));

  // R5
  ok_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    headerOk |=> headerOk);

  // R5
  ok_on_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(headerOk) |-> $past(inValid));

  // R7
  no_pay_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (payLast && payReady) |=> !payValid);

  // R8
  exclusive_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(headerOk && headerError));

endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
  import cfg_hdr_pkg::*;
#(
  parameter int FIELDS = 4,
  parameter int PLEN_W = 32,
  localparam int FIDX_W = $clog2(FIELDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [7:0]        fieldData,
  output logic [FIDX_W-1:0] fieldIdx,
  output logic              fieldValid,
  output logic              headerOk,
  output logic              headerError,
  output logic [PLEN_W-1:0] payloadLength,
  output logic [7:0]        payData,
  output logic              payValid,
  output logic              payFirst,
  output logic              payLast,
  input  logic              payReady
);

  dpCtl_t   ctl;
  dpFlags_t flags;

  cfg_hdr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .payReady(payReady),
    .flags(flags), .ctl(ctl), .inReady(inReady), .payValid(payValid),
    .payFirst(payFirst), .payLast(payLast), .fieldValid(fieldValid),
    .headerOk(headerOk), .headerError(headerError)
  );

  cfg_hdr_dp #(.FIELDS(FIELDS), .PLEN_W(PLEN_W)) uDp (
    .clk(clk), .rstN(rstN), .inData(inData), .ctl(ctl), .flags(flags),
    .fieldIdx(fieldIdx), .payloadLength(payloadLength)
  );

  assign fieldData = inData;
  assign payData   = inData;

endmodule

// File: tb/sim_cfg_hdr_parser.sv
module sim_cfg_hdr_parser;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  fieldData;
  logic [1:0]  fieldIdx;
  logic        fieldValid;
  logic        headerOk;
  logic        headerError;
  logic [31:0] payloadLength;
  logic [7:0]  payData;
  logic        payValid;
  logic        payFirst;
  logic        payLast;
  logic        payReady = 1'b1;

  int checks = 0;
  int errors = 0;

  logic [7:0] img[$];
  int kindQ[$];   // 0 header, 1 field, 2 payload, 3 dropped
  int fidxQ[$];
  int firstQ[$];
  int lastQ[$];
  int errAt, okAt, payExp;
  int fieldExp[4];
  int fieldSeen[4];
  int paySeen;
  logic [31:0] plenExp;
  int pos;
  logic takeNow;
  int curKind;
  logic erred, expOk, expReady, expPV, expFV;
  string readyTag;

  cfg_hdr_parser u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .fieldData(fieldData), .fieldIdx(fieldIdx), .fieldValid(fieldValid),
    .headerOk(headerOk), .headerError(headerError), .payloadLength(payloadLength),
    .payData(payData), .payValid(payValid), .payFirst(payFirst), .payLast(payLast),
    .payReady(payReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] sigRef(input int i);
    logic [7:0] s[13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                          8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
    return s[i];
  endfunction

  task automatic buildImg(input int badSig, input int l0, input int l1, input int l2,
                          input int l3, input logic [7:0] pTag, input int plen,
                          input int trail);
    int lens[4];
    lens = '{l0, l1, l2, l3};
    img.delete();
    for (int i = 0; i < 13; i++) img.push_back(sigRef(i) ^ ((i == badSig) ? 8'h40 : 8'h00));
    for (int f = 0; f < 4; f++) begin
      img.push_back((f == 2) ? 8'h65 : 8'h61 + 8'(f));
      img.push_back(8'(lens[f] >> 8));
      img.push_back(8'(lens[f]));
      for (int j = 0; j < lens[f]; j++) img.push_back(8'(f * 16 + j + 1));
    end
    img.push_back(pTag);
    for (int b = 3; b >= 0; b--) img.push_back(8'(plen >> (8 * b)));
    for (int j = 0; j < plen; j++) img.push_back(8'(j * 7 + 3));
    for (int j = 0; j < trail; j++) img.push_back(8'hA5 + 8'(j));
  endtask

  // independent walk over the whole image, classifying each byte
  task automatic analyze();
    int i, len, n;
    n = img.size();
    kindQ.delete(); fidxQ.delete(); firstQ.delete(); lastQ.delete();
    for (int k = 0; k < n; k++) begin
      kindQ.push_back(3); fidxQ.push_back(0); firstQ.push_back(0); lastQ.push_back(0);
    end
    errAt = -1; okAt = -1; payExp = 0; plenExp = '0;
    for (int f = 0; f < 4; f++) fieldExp[f] = 0;
    for (i = 0; i < 13; i++) begin
      kindQ[i] = 0;
      if (img[i] != sigRef(i)) begin errAt = i; return; end
    end
    for (int f = 0; f < 4; f++) begin
      kindQ[i] = 0; kindQ[i+1] = 0; kindQ[i+2] = 0;
      len = {img[i+1], img[i+2]};
      i += 3;
      for (int j = 0; j < len; j++) begin
        kindQ[i] = 1; fidxQ[i] = f; i++;
      end
      fieldExp[f] = len;
    end
    kindQ[i] = 0;
    if (img[i] != 8'h65) begin errAt = i; return; end
    i++;
    plenExp = {img[i], img[i+1], img[i+2], img[i+3]};
    for (int k = 0; k < 4; k++) kindQ[i+k] = 0;
    okAt = i + 3;
    i += 4;
    payExp = int'(plenExp);
    for (int j = 0; j < payExp; j++) begin
      kindQ[i] = 2; firstQ[i] = (j == 0); lastQ[i] = (j == payExp - 1); i++;
    end
  endtask

  // reference comparison on every clock, mid-cycle
  always @(negedge clk) begin
    if (!rstN) begin
      pos = 0; paySeen = 0; takeNow = 1'b0;
      for (int f = 0; f < 4; f++) fieldSeen[f] = 0;
    end else begin
      curKind  = (pos < kindQ.size()) ? kindQ[pos] : 3;
      erred    = (errAt >= 0) && (pos > errAt);
      expOk    = (okAt >= 0) && (pos > okAt);
      expReady = (!erred && curKind == 2) ? payReady : 1'b1;
      expPV    = inValid && !erred && curKind == 2;
      expFV    = inValid && !erred && curKind == 1;
      readyTag = (curKind == 3) ? "R7" : "R9";
      chk(readyTag, 32'(inReady), 32'(expReady));
      chk("R8", 32'(headerError), 32'(erred));
      chk("R5", 32'(headerOk), 32'(expOk));
      if (expOk) chk("R5", payloadLength, plenExp);
      chk("R6", 32'(payValid), 32'(expPV));
      if (expPV) begin
        chk("R6", 32'(payData), 32'(img[pos]));
        chk("R6", 32'(payFirst), 32'(firstQ[pos]));
        chk("R6", 32'(payLast), 32'(lastQ[pos]));
      end
      chk("R2", 32'(fieldValid), 32'(expFV));
      if (expFV) begin
        chk("R2", 32'(fieldIdx), 32'(fidxQ[pos]));
        chk("R2", 32'(fieldData), 32'(img[pos]));
      end
      if (fieldValid) fieldSeen[fieldIdx]++;
      if (payValid && payReady) paySeen++;
      takeNow = inValid && inReady;
      if (inValid && expReady) pos++;
    end
  end

  // readyMode: 0 random, 1 always ready, 2 mostly stalled
  task automatic runImage(input int readyMode);
    int k, n;
    analyze();
    n = img.size();
    rstN = 1'b0; inValid = 1'b0; payReady = 1'b1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10
    chk("R10", 32'(headerOk), 32'd0);
    chk("R10", 32'(headerError), 32'd0);
    chk("R10", 32'(inReady), 32'd1);
    chk("R10", 32'(payValid), 32'd0);
    chk("R10", 32'(fieldValid), 32'd0);
    k = 0;
    while (k < n) begin
      @(posedge clk);
      #1;
      if (takeNow) k++;
      inValid  = (k < n) && (($urandom % 4) != 0);
      inData   = (k < n) ? img[k] : 8'h00;
      payReady = (readyMode == 1) ? 1'b1 :
                 (readyMode == 2) ? (($urandom % 10) < 3) : (($urandom % 3) != 0);
    end
    inValid = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    // normal image, one empty section, random stalls
    buildImg(-1, 3, 0, 2, 4, 8'h65, 5, 3);
    runImage(0);
    // R3
    chk("R3", 32'(fieldSeen[1]), 32'(fieldExp[1]));
    chk("R3", 32'(fieldSeen[2]), 32'(fieldExp[2]));
    chk("R6", 32'(paySeen), 32'(payExp));

    // one-byte payload: first and last together, under heavy stall
    buildImg(-1, 1, 1, 1, 1, 8'h65, 1, 4);
    runImage(2);
    chk("R6", 32'(paySeen), 32'd1);
    chk("R7", 32'(headerOk), 32'd1);

    // corrupted signature byte
    buildImg(7, 2, 2, 2, 2, 8'h65, 4, 0);
    runImage(1);
    // R1
    chk("R1", 32'(headerError), 32'd1);
    chk("R8", 32'(paySeen), 32'd0);

    // wrong payload tag
    buildImg(-1, 2, 3, 0, 1, 8'h66, 6, 2);
    runImage(0);
    // R4
    chk("R4", 32'(headerError), 32'd1);
    chk("R8", 32'(paySeen), 32'd0);
    chk("R8", 32'(headerOk), 32'd0);

    // zero payload length, every section empty
    buildImg(-1, 0, 0, 0, 0, 8'h65, 0, 5);
    runImage(0);
    // R11
    chk("R11", 32'(headerOk), 32'd1);
    chk("R11", 32'(paySeen), 32'd0);
    chk("R11", payloadLength, 32'd0);

    // long payload with long text sections
    buildImg(-1, 20, 9, 1, 12, 8'h65, 40, 2);
    runImage(0);
    chk("R6", 32'(paySeen), 32'd40);
    chk("R2", 32'(fieldSeen[0]), 32'd20);
    chk("R2", 32'(fieldSeen[3]), 32'd12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule